// File: doc/BRIEF.md
# Instruction Cache Tag Invalidation Sequencer

This block clears the valid bits of a 512-entry instruction-cache tag array. Software starts a full clear by setting a start bit in a control register. The block then sweeps the tag write port through every index, one index per cycle, in ascending order. While the sweep runs it holds off instruction fetches, and it raises a one-cycle completion pulse after the last index has been cleared.

A single tag entry can also be cleared from a supplied address. Bits [12:4] of that address select the index, and the clear takes one cycle. A second control bit, when set, blocks these single-entry clears. Two request sources share the block: source 0 is the processor core and source 1 is the debug port. When both sources ask in the same cycle, the core wins.

Reset clears the control register, including the enable bit 31. The tag array is not touched by reset, so software must run a full sweep before it turns the cache on.

Top module: `itag_inval_seq`

## Requirements
- R1: After reset the control register reads 0, including bit 31. `tag_clr_vld`, `fetch_hold`, `busy` and `done` are all low.
- R2: A control write with bit 24 set, made while idle, starts a sweep: `busy` is high from the next cycle. Bit 24 always reads back as 0. Every other written bit is stored as written.
- R3: A sweep drives `tag_clr_vld` for exactly 512 consecutive cycles. `tag_wr_idx` runs 0, 1, …, 511 in that order.
- R4: `fetch_hold` is high in every cycle of a sweep.
- R5: `done` is high for exactly one cycle: the cycle after the strobe for index 511. In that cycle `busy` and `tag_clr_vld` are low.
- R6: During a sweep, a write with bit 24 set stores the other bits but does not restart or disturb the index sequence.
- R7: A single-entry request made while idle, with control bit 28 clear, produces one strobe on the next cycle. `tag_wr_idx` equals address bits [12:4] and `fetch_hold` is high for that cycle only. `busy` stays low.
- R8: While control bit 28 is 1, a single-entry request produces no strobe and no hold.
- R9: A single-entry request made during a sweep, or in the same cycle as a write that starts one, is dropped. No extra strobe follows the sweep.
- R10: Source 0 (core) wins over source 1 (debug) for simultaneous control writes and for simultaneous single-entry requests. The losing request is discarded. Either source alone is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_ctl_wr | input | NUM_SRC | Control-register write strobe per source (0 = core, 1 = debug) |
| src_ctl_data | input | NUM_SRC*CTRL_W | Write data per source, source i at bits [i*CTRL_W +: CTRL_W] |
| src_line_req | input | NUM_SRC | Single-entry clear request per source |
| src_line_addr | input | NUM_SRC*ADDR_W | Address per source; bits [12:4] pick the entry |
| ctl_rd_data | output | CTRL_W | Control register contents |
| tag_wr_idx | output | INDEX_W | Tag-array index being cleared |
| tag_clr_vld | output | 1 | Clear-valid strobe for the tag array |
| fetch_hold | output | 1 | Holds off instruction fetches |
| busy | output | 1 | Full sweep in progress |
| done | output | 1 | One-cycle pulse when the sweep ends |

## Verification
The bench follows every cycle of a sweep. An off-by-one terminal count would show up as 511 or 513 strobes, or as `done` landing on the last strobe. A start bit that does not clear itself would restart the sweep, and the restart is caught by a control write injected mid-sweep. A single-entry request injected mid-sweep, and one raised in the same cycle as the sweep start, must not produce a stray strobe. A design that queued or leaked these requests would show a clear after `done`. Simultaneous requests from both sources check that only the core's index appears and that the debug request does not follow a cycle later. Setting bit 28 checks that a design ignoring the gate would strobe anyway.

// File: rtl/itag_pkg.sv
package itag_pkg;
   typedef enum logic {
      SWP_IDLE = 1'b0,
      SWP_RUN  = 1'b1
   } swp_state_e;

   localparam int unsigned SRC_CORE  = 0;
   localparam int unsigned SRC_DEBUG = 1;
endpackage

// File: rtl/itag_src_arb.sv
module itag_src_arb #(
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned W       = 32
) (
   input  logic [NUM_SRC-1:0]   req,
   input  logic [NUM_SRC*W-1:0] data,
   output logic                 gnt_vld,
   output logic [W-1:0]         gnt_data
);
   if (NUM_SRC == 1) begin : g_single
      assign gnt_vld  = req[0];
      assign gnt_data = data[W-1:0];
   end else begin : g_prio
      // lowest index wins: last assignment in a descending scan
      always_comb begin
         gnt_vld  = 1'b0;
         gnt_data = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
               gnt_vld  = 1'b1;
               gnt_data = data[i*W +: W];
            end
         end
      end
   end
endmodule

// File: rtl/itag_ctl_reg.sv
module itag_ctl_reg #(
   parameter int unsigned CTRL_W    = 32,
   parameter int unsigned SWEEP_BIT = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vld,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              busy,
   output logic [CTRL_W-1:0] ctl_q,
   output logic              sweep_go
);
   localparam logic [CTRL_W-1:0] KEEP_MASK = ~(CTRL_W'(1) << SWEEP_BIT);

   assign sweep_go = wr_vld & wr_data[SWEEP_BIT] & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_vld) begin
         ctl_q <= wr_data & KEEP_MASK;
      end
   end
endmodule

// File: rtl/itag_sweep.sv
module itag_sweep
   import itag_pkg::*;
#(
   parameter int unsigned INDEX_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               active,
   output logic [INDEX_W-1:0] cnt,
   output logic               done
);
   localparam logic [INDEX_W-1:0] LAST_IDX = '1;

   swp_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SWP_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SWP_IDLE: begin
               if (start) begin
                  state <= SWP_RUN;
                  cnt   <= '0;
               end
            end
            SWP_RUN: begin
               if (cnt == LAST_IDX) begin
                  state <= SWP_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SWP_IDLE;
         endcase
      end
   end

   assign active = (state == SWP_RUN);
endmodule

// File: rtl/itag_line_clr.sv
module itag_line_clr #(
   parameter int unsigned INDEX_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [INDEX_W-1:0] idx_in,
   output logic               pend,
   output logic [INDEX_W-1:0] idx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         idx_q <= '0;
      end else begin
         pend <= fire;
         if (fire) idx_q <= idx_in;
      end
   end
endmodule

// File: rtl/itag_inval_seq.sv
module itag_inval_seq
   import itag_pkg::*;
#(
   parameter int unsigned NUM_SRC      = 2,
   parameter int unsigned CTRL_W       = 32,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned INDEX_W      = 9,
   parameter int unsigned LINE_LSB     = 4,
   parameter int unsigned SWEEP_BIT    = 24,
   parameter int unsigned GATE_BIT     = 28,
   parameter bit          LINE_GATE_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_ctl_wr,
   input  logic [NUM_SRC*CTRL_W-1:0] src_ctl_data,
   input  logic [NUM_SRC-1:0]        src_line_req,
   input  logic [NUM_SRC*ADDR_W-1:0] src_line_addr,
   output logic [CTRL_W-1:0]         ctl_rd_data,
   output logic [INDEX_W-1:0]        tag_wr_idx,
   output logic                      tag_clr_vld,
   output logic                      fetch_hold,
   output logic                      busy,
   output logic                      done
);
   localparam int unsigned IDX_HI = LINE_LSB + INDEX_W - 1;

   if (NUM_SRC < 1 || NUM_SRC <= SRC_DEBUG) begin : g_bad_src
      $error("NUM_SRC must cover core and debug sources");
   end
   if (SWEEP_BIT >= CTRL_W || GATE_BIT >= CTRL_W || SWEEP_BIT == GATE_BIT) begin : g_bad_bits
      $error("control bit positions out of range or overlapping");
   end
   if (LINE_LSB < 1 || IDX_HI + 1 >= ADDR_W) begin : g_bad_addr
      $error("index field must sit strictly inside the address");
   end
   if (INDEX_W < 1 || INDEX_W > 16) begin : g_bad_idx
      $error("INDEX_W out of supported range");
   end

   logic              ctl_gnt;
   logic [CTRL_W-1:0] ctl_gnt_data;
   logic              line_gnt;
   logic [ADDR_W-1:0] line_gnt_addr;
   logic [CTRL_W-1:0] ctl_q;
   logic              sweep_go;
   logic              sweep_act;
   logic [INDEX_W-1:0] sweep_cnt;
   logic              line_allow;
   logic              line_fire;
   logic              line_pend;
   logic [INDEX_W-1:0] line_idx;
   logic              addr_unused;

   itag_src_arb #(.NUM_SRC(NUM_SRC), .W(CTRL_W)) u_ctl_arb (
      .req      (src_ctl_wr),
      .data     (src_ctl_data),
      .gnt_vld  (ctl_gnt),
      .gnt_data (ctl_gnt_data)
   );

   itag_src_arb #(.NUM_SRC(NUM_SRC), .W(ADDR_W)) u_line_arb (
      .req      (src_line_req),
      .data     (src_line_addr),
      .gnt_vld  (line_gnt),
      .gnt_data (line_gnt_addr)
   );

   itag_ctl_reg #(.CTRL_W(CTRL_W), .SWEEP_BIT(SWEEP_BIT)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_vld   (ctl_gnt),
      .wr_data  (ctl_gnt_data),
      .busy     (sweep_act),
      .ctl_q    (ctl_q),
      .sweep_go (sweep_go)
   );

   itag_sweep #(.INDEX_W(INDEX_W)) u_sweep (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (sweep_go),
      .active (sweep_act),
      .cnt    (sweep_cnt),
      .done   (done)
   );

   if (LINE_GATE_EN) begin : g_gate
      assign line_allow = ~ctl_q[GATE_BIT];
   end else begin : g_nogate
      assign line_allow = 1'b1;
   end

   // a sweep (running or starting) covers every line, so the request is dropped
   assign line_fire   = line_gnt & line_allow & ~sweep_act & ~sweep_go;
   assign addr_unused = ^{line_gnt_addr[ADDR_W-1:IDX_HI+1], line_gnt_addr[LINE_LSB-1:0]};

   itag_line_clr #(.INDEX_W(INDEX_W)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (line_fire),
      .idx_in (line_gnt_addr[IDX_HI:LINE_LSB]),
      .pend   (line_pend),
      .idx_q  (line_idx)
   );

   assign tag_clr_vld = sweep_act | line_pend;
   assign tag_wr_idx  = sweep_act ? sweep_cnt : line_idx;
   assign fetch_hold  = sweep_act | line_pend;
   assign busy        = sweep_act;
   assign ctl_rd_data = ctl_q;
endmodule

// File: rtl/itag_inval_chk.sv
module itag_inval_chk #(
   parameter int unsigned INDEX_W = 9,
   parameter bit          GATE_EN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic               tag_clr_vld,
   input logic [INDEX_W-1:0] tag_wr_idx,
   input logic               fetch_hold,
   input logic               line_any,
   input logic               gate_set
);
   localparam logic [INDEX_W-1:0] LAST_IDX = '1;

   AST_SWEEP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> tag_wr_idx == '0); // R3
   AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> tag_wr_idx == $past(tag_wr_idx) + 1'b1); // R3
   AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (fetch_hold && tag_clr_vld)); // R4
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !tag_clr_vld && $past(busy) && $past(tag_wr_idx) == LAST_IDX)); // R5
   AST_LINE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_clr_vld && !busy) |-> ($past(line_any) && !$past(busy) && (!GATE_EN || !$past(gate_set)))); // R8
   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_clr_vld && !busy) |-> fetch_hold); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(line_any)) |-> (!tag_clr_vld && !fetch_hold)); // R9
endmodule

bind itag_inval_seq itag_inval_chk #(.INDEX_W(INDEX_W), .GATE_EN(LINE_GATE_EN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .tag_clr_vld (tag_clr_vld),
   .tag_wr_idx  (tag_wr_idx),
   .fetch_hold  (fetch_hold),
   .line_any    (|src_line_req),
   .gate_set    (ctl_rd_data[GATE_BIT])
);

// File: tb/itag_inval_seq_tb.sv
module itag_inval_seq_tb_top;
   localparam int unsigned NS = 2;
   localparam int unsigned CW = 32;
   localparam int unsigned AW = 32;
   localparam int unsigned IW = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NS-1:0]    src_ctl_wr = '0;
   logic [NS*CW-1:0] src_ctl_data = '0;
   logic [NS-1:0]    src_line_req = '0;
   logic [NS*AW-1:0] src_line_addr = '0;
   logic [CW-1:0]    ctl_rd_data;
   logic [IW-1:0]    tag_wr_idx;
   logic             tag_clr_vld;
   logic             fetch_hold;
   logic             busy;
   logic             done;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   itag_inval_seq dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_ctl_wr    (src_ctl_wr),
      .src_ctl_data  (src_ctl_data),
      .src_line_req  (src_line_req),
      .src_line_addr (src_line_addr),
      .ctl_rd_data   (ctl_rd_data),
      .tag_wr_idx    (tag_wr_idx),
      .tag_clr_vld   (tag_clr_vld),
      .fetch_hold    (fetch_hold),
      .busy          (busy),
      .done          (done)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_in();
      src_ctl_wr    = '0;
      src_ctl_data  = '0;
      src_line_req  = '0;
      src_line_addr = '0;
   endtask

   task automatic ctl_write(input int src, input logic [31:0] val);
      @(negedge clk);
      clear_in();
      src_ctl_wr[src] = 1'b1;
      src_ctl_data[src*CW +: CW] = val;
      @(negedge clk);
      clear_in();
   endtask

   task automatic t_reset(input bit prewrite);
      if (prewrite) ctl_write(0, 32'h8000_0011);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ctl after reset", ctl_rd_data, 32'h0);
      chk("R1", "outputs idle", {28'h0, tag_clr_vld, fetch_hold, busy, done}, 32'h0);
   endtask

   task automatic t_gate_blocks();
      ctl_write(0, 32'h1234_5678);
      chk("R2", "plain write readback", ctl_rd_data, 32'h1234_5678);
      chk("R2", "no sweep without bit24", {31'h0, busy}, 32'h0);
      @(negedge clk);
      src_line_req[0] = 1'b1;
      src_line_addr[0 +: AW] = 32'h0000_1A30;
      @(negedge clk);
      clear_in();
      chk("R8", "gated line strobe", {30'h0, tag_clr_vld, fetch_hold}, 32'h0);
      @(negedge clk);
      chk("R8", "gated line later", {30'h0, tag_clr_vld, fetch_hold}, 32'h0);
   endtask

   // full sweep; inject = mid-sweep ctl write and line request; collide = line request with the start
   task automatic t_sweep(input int src, input bit inject, input bit collide);
      int idx_err = 0;
      int hold_err = 0;
      @(negedge clk);
      clear_in();
      src_ctl_wr[src] = 1'b1;
      src_ctl_data[src*CW +: CW] = 32'h8100_0000;
      if (collide) begin
         src_line_req[1] = 1'b1;
         src_line_addr[AW +: AW] = 32'h0000_0050;
      end
      @(negedge clk);
      clear_in();
      chk("R2", "busy after start", {31'h0, busy}, 32'h1);
      for (int k = 0; k < 512; k++) begin
         if (tag_wr_idx !== k[IW-1:0] || tag_clr_vld !== 1'b1 || busy !== 1'b1 || done !== 1'b0) idx_err++;
         if (fetch_hold !== 1'b1) hold_err++;
         clear_in();
         if (inject && k == 100) begin
            src_ctl_wr[1] = 1'b1;
            src_ctl_data[CW +: CW] = 32'h0100_00FF;
         end
         if (inject && k == 200) begin
            src_line_req[0] = 1'b1;
            src_line_addr[0 +: AW] = 32'h0000_1A30;
         end
         @(negedge clk);
      end
      clear_in();
      chk("R3", "sweep index/strobe mismatches", idx_err, 0);
      chk("R4", "sweep hold gaps", hold_err, 0);
      chk("R5", "done after last", {28'h0, done, busy, tag_clr_vld, fetch_hold}, 32'h8);
      if (inject) begin
         chk("R6", "mid-sweep write stored, bit24 dropped", ctl_rd_data, 32'h0000_00FF);
         chk("R6", "no restart", idx_err, 0);
      end else begin
         chk("R2", "bit24 self-clears", ctl_rd_data, 32'h8000_0000);
      end
      @(negedge clk);
      chk("R5", "done single cycle", {31'h0, done}, 32'h0);
      chk("R9", "no late line strobe", {30'h0, tag_clr_vld, busy}, 32'h0);
   endtask

   task automatic t_line(input int src, input logic [31:0] addr, input logic [8:0] exp_idx);
      @(negedge clk);
      clear_in();
      src_line_req[src] = 1'b1;
      src_line_addr[src*AW +: AW] = addr;
      @(negedge clk);
      clear_in();
      chk("R7", "line strobe", {29'h0, tag_clr_vld, fetch_hold, busy}, 32'h6);
      chk("R7", "line index", tag_wr_idx, exp_idx);
      @(negedge clk);
      chk("R7", "line one cycle", {30'h0, tag_clr_vld, fetch_hold}, 32'h0);
   endtask

   task automatic t_dual();
      @(negedge clk);
      clear_in();
      src_ctl_wr = 2'b11;
      src_ctl_data[0 +: CW]  = 32'h0000_0011;
      src_ctl_data[CW +: CW] = 32'h0100_0000;
      @(negedge clk);
      clear_in();
      chk("R10", "core ctl wins", ctl_rd_data, 32'h0000_0011);
      chk("R10", "debug start discarded", {31'h0, busy}, 32'h0);
      @(negedge clk);
      src_line_req = 2'b11;
      src_line_addr[0 +: AW]  = 32'h0000_0040;
      src_line_addr[AW +: AW] = 32'h0000_1FF0;
      @(negedge clk);
      clear_in();
      chk("R10", "core line wins", {22'h0, tag_clr_vld, tag_wr_idx}, {22'h0, 1'b1, 9'd4});
      @(negedge clk);
      chk("R10", "debug line discarded", {31'h0, tag_clr_vld}, 32'h0);
      t_line(1, 32'h0000_1FF0, 9'h1FF);
   endtask

   initial begin
      clear_in();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset(1'b0);
      t_gate_blocks();
      t_sweep(0, 1'b0, 1'b0);
      t_line(0, 32'h0000_1A30, 9'h1A3);
      t_sweep(1, 1'b1, 1'b0);
      ctl_write(0, 32'h0);
      t_sweep(0, 1'b0, 1'b1);
      t_dual();
      t_reset(1'b1);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule